// File: doc/BRIEF.md
# CPU Interrupt Enable and Mode Controller

This block is the interrupt-control slice of an 8-bit processor core. It keeps the two interrupt-enable flip-flops (a live enable and a saved copy), the 2-bit maskable-interrupt mode and the 8-bit vector-base register. At the last clock of every instruction it looks at the non-maskable and maskable request inputs. It decides which request, if any, to take, updates the enable pair and produces the address where execution resumes.

The instruction decoder drives single-cycle strobes into the block: disable, enable, mode select, return-from-NMI, load of the vector base and the read of the vector-base or refresh register into the accumulator. A taken maskable request runs a short acknowledge sequence with two wait cycles. The device vector is sampled at its end. The block then presents the restart address, or the table pointer in mode 2. Mode-0 acceptance is only flagged, because the device-supplied instruction is run elsewhere.

Top module: `irq_mode_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it: iff1_o=0, iff2_o=0, mode_o=0, pv_o=0, and take_nmi_o, take_int_o, ack_wait_o, tgt_valid_o and mode0_o are all 0.
- R2: An op_di_i strobe clears iff1_o and iff2_o. An op_ei_i strobe sets both. The new values show in the cycle after the strobe.
- R3: Requests are sampled only in a cycle with insn_end_i=1. Nothing is taken in a cycle where insn_end_i comes together with op_ei_i or op_di_i.
- R4: No request of either kind is taken in a sampling cycle with busreq_i=1.
- R5: nmi_i=1 is taken whatever the value of iff1_o, and it wins over int_i. In the next cycle take_nmi_o=1, tgt_valid_o=1, tgt_addr_o=16'h0066, iff2_o holds the old iff1_o, and iff1_o=0.
- R6: int_i is taken only with iff1_o=1 and nmi_i=0. In the next cycle take_int_o=1 and both enables are 0.
- R7: After a maskable request is taken, ack_wait_o is 1 for exactly the two following cycles. In the third cycle tgt_valid_o=1, and ack_vec_i is taken from the clock edge that ends the second wait cycle.
- R8: Target address by mode: mode 1 gives 16'h0038. Mode 0 gives 16'h0000 with mode0_o=1. Mode 2 gives {vector base, ack_vec_i with bit 0 forced to 0}.
- R9: An op_im_i strobe loads mode_o from im_sel_i when im_sel_i is 0, 1 or 2. The value 3 leaves mode_o unchanged.
- R10: An op_retn_i strobe copies iff2_o into iff1_o.
- R11: An op_ldair_i strobe loads pv_o with iff2_o. pv_o holds its value in every other cycle.
- R12: No request is taken while the acknowledge sequence is running (ack_wait_o=1), even when insn_end_i comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, level |
| int_i | input | 1 | Maskable request, level |
| busreq_i | input | 1 | External bus request active |
| insn_end_i | input | 1 | Last clock of the current instruction |
| op_di_i | input | 1 | Disable-interrupts strobe |
| op_ei_i | input | 1 | Enable-interrupts strobe |
| op_retn_i | input | 1 | Return-from-NMI strobe |
| op_im_i | input | 1 | Mode-select strobe |
| im_sel_i | input | 2 | Requested mode (0, 1, 2; 3 is ignored) |
| op_ldair_i | input | 1 | Read of vector-base or refresh register into the accumulator |
| ireg_we_i | input | 1 | Vector-base register write enable |
| ireg_d_i | input | 8 | Vector-base write data |
| ack_vec_i | input | 8 | Device vector on the bus during acknowledge |
| iff1_o | output | 1 | Live interrupt enable |
| iff2_o | output | 1 | Saved interrupt enable |
| mode_o | output | 2 | Current maskable-interrupt mode |
| pv_o | output | 1 | Parity/overflow flag value from the last register read |
| take_nmi_o | output | 1 | Non-maskable request taken (one cycle) |
| take_int_o | output | 1 | Maskable request taken (one cycle) |
| ack_wait_o | output | 1 | Inserted acknowledge wait cycle |
| tgt_valid_o | output | 1 | tgt_addr_o is valid (one cycle) |
| tgt_addr_o | output | 16 | Restart address or vector-table pointer |
| mode0_o | output | 1 | Taken request uses mode 0 (device-supplied instruction) |

## Verification
Every result of this block is registered, so the bench drives inputs on the falling edge and reads outputs at the next falling edge. Strobe effects, take pulses and the non-maskable target are all due one cycle after the sampling edge. The maskable target is due three cycles after that edge, after two wait cycles, and the bench reads ack_wait_o in each of the two cycles before it checks the address. A table of request patterns, each walked through the same timing, covers priority, masking, bus-request blocking and all three modes. Directed cases then cover strobe suppression of sampling, saving and restoring of the enable, flag capture, the ignored mode code and requests that arrive during an acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [1:0] MODE_0 = 2'd0;
  localparam logic [1:0] MODE_1 = 2'd1;
  localparam logic [1:0] MODE_2 = 2'd2;
  localparam logic [1:0] MODE_X = 2'd3;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_WAIT1 = 2'd1,
    ACK_WAIT2 = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irqc_state.sv
module irqc_state
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_di,
  input  logic              op_ei,
  input  logic              op_retn,
  input  logic              op_im,
  input  logic [1:0]        im_sel,
  input  logic              op_ldair,
  input  logic              ireg_we,
  input  logic [DATA_W-1:0] ireg_d,
  input  logic              acc_nmi,
  input  logic              acc_int,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        mode,
  output logic [DATA_W-1:0] ireg,
  output logic              pv
);
  logic       iff1_n, iff2_n, pv_n;
  logic [1:0] mode_n;

  always_comb begin
    iff1_n = iff1;
    iff2_n = iff2;
    if (op_di) begin
      iff1_n = 1'b0;
      iff2_n = 1'b0;
    end else if (op_ei) begin
      iff1_n = 1'b1;
      iff2_n = 1'b1;
    end else if (op_retn) begin
      iff1_n = iff2;
    end
    if (acc_nmi) begin
      iff2_n = iff1;
      iff1_n = 1'b0;
    end else if (acc_int) begin
      iff1_n = 1'b0;
      iff2_n = 1'b0;
    end
  end

  always_comb begin
    mode_n = mode;
    if (op_im && (im_sel != MODE_X)) mode_n = im_sel;
    pv_n = pv;
    if (op_ldair) pv_n = iff2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      mode <= MODE_0;
      pv   <= 1'b0;
    end else begin
      iff1 <= iff1_n;
      iff2 <= iff2_n;
      mode <= mode_n;
      pv   <= pv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ireg <= '0;
    else if (ireg_we) ireg <= ireg_d;
  end

  p_ei_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_ei && !op_di |=> iff1 && iff2);
  p_nmi_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_nmi |=> !iff1 && (iff2 == $past(iff1)));
  p_int_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int |=> !iff1 && !iff2);
  p_retn_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_retn && !op_di && !op_ei && !acc_nmi && !acc_int |=> iff1 == $past(iff2));
  p_pv_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_ldair |=> pv == $past(iff2));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter (
  input  logic insn_end,
  input  logic op_di,
  input  logic op_ei,
  input  logic busreq,
  input  logic seq_idle,
  input  logic nmi,
  input  logic irq,
  input  logic iff1,
  output logic acc_nmi,
  output logic acc_int
);
  logic sample_ok;

  always_comb begin
    sample_ok = insn_end && !op_di && !op_ei && !busreq && seq_idle;
    acc_nmi   = sample_ok && nmi;
    acc_int   = sample_ok && !nmi && irq && iff1;
  end

  always_comb begin
    a_excl_r5: assert (!(acc_nmi && acc_int));
  end
endmodule

// File: rtl/irqc_ack_seq.sv
module irqc_ack_seq
  import irqc_pkg::*;
#(
  parameter int                  DATA_W   = 8,
  parameter int                  ADDR_W   = 2 * DATA_W,
  parameter logic [ADDR_W-1:0]   NMI_ADDR = 16'h0066,
  parameter logic [ADDR_W-1:0]   M1_ADDR  = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_nmi,
  input  logic              acc_int,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] ireg,
  input  logic [DATA_W-1:0] vec,
  output logic              seq_idle,
  output logic              take_nmi,
  output logic              take_int,
  output logic              ack_wait,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              mode0
);
  localparam logic [ADDR_W-1:0] LSB_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

  ack_state_e        st, st_n;
  logic [1:0]        mode_q, mode_n;
  logic              take_nmi_n, take_int_n, valid_n, mode0_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    st_n       = st;
    mode_n     = mode_q;
    take_nmi_n = acc_nmi;
    take_int_n = acc_int;
    valid_n    = 1'b0;
    mode0_n    = 1'b0;
    addr_n     = tgt_addr;
    case (st)
      ACK_IDLE: begin
        if (acc_nmi) begin
          valid_n = 1'b1;
          addr_n  = NMI_ADDR;
        end else if (acc_int) begin
          st_n   = ACK_WAIT1;
          mode_n = mode;
        end
      end
      ACK_WAIT1: st_n = ACK_WAIT2;
      ACK_WAIT2: begin
        st_n    = ACK_IDLE;
        valid_n = 1'b1;
        case (mode_q)
          MODE_0: begin
            addr_n  = '0;
            mode0_n = 1'b1;
          end
          MODE_1:  addr_n = M1_ADDR;
          default: addr_n = {ireg, vec} & LSB_MASK;
        endcase
      end
      default: st_n = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ACK_IDLE;
      mode_q    <= MODE_0;
      take_nmi  <= 1'b0;
      take_int  <= 1'b0;
      tgt_valid <= 1'b0;
      tgt_addr  <= '0;
      mode0     <= 1'b0;
    end else begin
      st        <= st_n;
      mode_q    <= mode_n;
      take_nmi  <= take_nmi_n;
      take_int  <= take_int_n;
      tgt_valid <= valid_n;
      tgt_addr  <= addr_n;
      mode0     <= mode0_n;
    end
  end

  always_comb begin
    seq_idle = (st == ACK_IDLE);
    ack_wait = !seq_idle;
  end

  p_wait_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_wait) |=> ack_wait);
  p_wait_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wait && $past(ack_wait) |=> !ack_wait && tgt_valid);
  p_nmi_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> tgt_valid && (tgt_addr == NMI_ADDR));
  p_int_starts_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> ack_wait && !tgt_valid);
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irqc_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 16'h0066,
  parameter logic [ADDR_W-1:0] M1_ADDR  = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              int_i,
  input  logic              busreq_i,
  input  logic              insn_end_i,
  input  logic              op_di_i,
  input  logic              op_ei_i,
  input  logic              op_retn_i,
  input  logic              op_im_i,
  input  logic [1:0]        im_sel_i,
  input  logic              op_ldair_i,
  input  logic              ireg_we_i,
  input  logic [DATA_W-1:0] ireg_d_i,
  input  logic [DATA_W-1:0] ack_vec_i,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        mode_o,
  output logic              pv_o,
  output logic              take_nmi_o,
  output logic              take_int_o,
  output logic              ack_wait_o,
  output logic              tgt_valid_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              mode0_o
);
  logic              acc_nmi, acc_int, seq_idle;
  logic [DATA_W-1:0] ireg;

  irqc_state #(.DATA_W(DATA_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .op_di(op_di_i), .op_ei(op_ei_i), .op_retn(op_retn_i),
    .op_im(op_im_i), .im_sel(im_sel_i), .op_ldair(op_ldair_i),
    .ireg_we(ireg_we_i), .ireg_d(ireg_d_i),
    .acc_nmi(acc_nmi), .acc_int(acc_int),
    .iff1(iff1_o), .iff2(iff2_o), .mode(mode_o), .ireg(ireg), .pv(pv_o)
  );

  irqc_arbiter u_arb (
    .insn_end(insn_end_i), .op_di(op_di_i), .op_ei(op_ei_i),
    .busreq(busreq_i), .seq_idle(seq_idle),
    .nmi(nmi_i), .irq(int_i), .iff1(iff1_o),
    .acc_nmi(acc_nmi), .acc_int(acc_int)
  );

  irqc_ack_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR), .M1_ADDR(M1_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_nmi(acc_nmi), .acc_int(acc_int),
    .mode(mode_o), .ireg(ireg), .vec(ack_vec_i),
    .seq_idle(seq_idle),
    .take_nmi(take_nmi_o), .take_int(take_int_o),
    .ack_wait(ack_wait_o), .tgt_valid(tgt_valid_o),
    .tgt_addr(tgt_addr_o), .mode0(mode0_o)
  );

  p_busreq_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi_o || take_int_o) |-> !$past(busreq_i));
  p_int_needs_iff1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_int_o |-> $past(iff1_o) && !$past(nmi_i));
  p_take_needs_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi_o || take_int_o) |-> $past(insn_end_i) && !$past(op_ei_i) && !$past(op_di_i));
  p_no_take_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wait_o && $past(ack_wait_o) |-> !take_nmi_o && !take_int_o);
  p_take_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi_o, take_int_o}));
endmodule

// File: tb/irq_mode_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_i, int_i, busreq_i, insn_end_i;
  logic        op_di_i, op_ei_i, op_retn_i, op_im_i, op_ldair_i, ireg_we_i;
  logic [1:0]  im_sel_i;
  logic [7:0]  ireg_d_i, ack_vec_i;
  logic        iff1_o, iff2_o, pv_o, take_nmi_o, take_int_o, ack_wait_o, tgt_valid_o, mode0_o;
  logic [1:0]  mode_o;
  logic [15:0] tgt_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mode_ctrl u_dut (.*);

  // vector: ei, nmi, int, busreq, mode[2], ireg[8], vec[8], kind[2], addr[16]
  // kind: 0 nothing taken, 1 non-maskable taken, 2 maskable taken
  localparam int NV = 9;
  localparam logic [39:0] TBL [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,2'd1,8'h00,8'h00,2'd1,16'h0066},
    {1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,8'h00,2'd1,16'h0066},
    {1'b1,1'b0,1'b1,1'b0,2'd1,8'h00,8'h00,2'd2,16'h0038},
    {1'b0,1'b0,1'b1,1'b0,2'd1,8'h00,8'h00,2'd0,16'h0000},
    {1'b1,1'b0,1'b1,1'b0,2'd2,8'h3A,8'h57,2'd2,16'h3A56},
    {1'b1,1'b1,1'b1,1'b0,2'd2,8'h12,8'h40,2'd1,16'h0066},
    {1'b1,1'b1,1'b1,1'b1,2'd1,8'h00,8'h00,2'd0,16'h0000},
    {1'b1,1'b0,1'b1,1'b0,2'd0,8'h00,8'hC7,2'd2,16'h0000},
    {1'b1,1'b0,1'b1,1'b0,2'd2,8'hFF,8'hFE,2'd2,16'hFFFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    nmi_i = 0; int_i = 0; busreq_i = 0; insn_end_i = 0;
    op_di_i = 0; op_ei_i = 0; op_retn_i = 0; op_im_i = 0; op_ldair_i = 0;
    ireg_we_i = 0; im_sel_i = 0; ireg_d_i = 0;
  endtask

  task automatic do_ei();    @(negedge clk); op_ei_i = 1;    @(negedge clk); op_ei_i = 0;    endtask
  task automatic do_di();    @(negedge clk); op_di_i = 1;    @(negedge clk); op_di_i = 0;    endtask
  task automatic do_retn();  @(negedge clk); op_retn_i = 1;  @(negedge clk); op_retn_i = 0;  endtask
  task automatic do_ldair(); @(negedge clk); op_ldair_i = 1; @(negedge clk); op_ldair_i = 0; endtask
  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); op_im_i = 1; im_sel_i = m; @(negedge clk); op_im_i = 0;
  endtask
  task automatic set_ireg(input logic [7:0] v);
    @(negedge clk); ireg_we_i = 1; ireg_d_i = v; @(negedge clk); ireg_we_i = 0;
  endtask

  initial begin
    clear_in();
    ack_vec_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 iff1 in reset", iff1_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 iff1", iff1_o, 0);
    chk("R1 iff2", iff2_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 pv", pv_o, 0);
    chk("R1 outputs", {take_nmi_o, take_int_o, ack_wait_o, tgt_valid_o, mode0_o}, 0);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic ei, nm, it, br;
      logic [1:0] md, kind;
      logic [7:0] ir, vc;
      logic [15:0] ad;
      {ei, nm, it, br, md, ir, vc, kind, ad} = TBL[i];
      do_di();
      set_mode(md);
      set_ireg(ir);
      if (ei) do_ei();
      @(negedge clk);
      nmi_i = nm; int_i = it; busreq_i = br; ack_vec_i = vc; insn_end_i = 1;
      @(negedge clk);
      nmi_i = 0; int_i = 0; busreq_i = 0; insn_end_i = 0;
      chk("R5 take_nmi", take_nmi_o, kind == 2'd1);
      chk("R6 take_int", take_int_o, kind == 2'd2);
      if (kind == 2'd1) begin
        chk("R5 valid", tgt_valid_o, 1);
        chk("R5 addr", tgt_addr_o, ad);
        chk("R5 iff2 saved", iff2_o, ei);
        chk("R5 iff1 cleared", iff1_o, 0);
      end else if (kind == 2'd2) begin
        chk("R7 wait 1", ack_wait_o, 1);
        chk("R6 iff cleared", {iff1_o, iff2_o}, 0);
        @(negedge clk);
        chk("R7 wait 2", ack_wait_o, 1);
        chk("R7 not valid yet", tgt_valid_o, 0);
        @(negedge clk);
        chk("R7 wait over", ack_wait_o, 0);
        chk("R7 valid", tgt_valid_o, 1);
        chk("R8 addr", tgt_addr_o, ad);
        chk("R8 mode0 flag", mode0_o, md == 2'd0);
      end else begin
        chk("R4 no valid", tgt_valid_o, 0);
        chk("R4 no wait", ack_wait_o, 0);
        chk("R6 iff kept", {iff1_o, iff2_o}, {ei, ei});
      end
      @(negedge clk);
    end

    // R2 strobes
    do_ei();
    chk("R2 ei", {iff1_o, iff2_o}, 2'b11);
    do_di();
    chk("R2 di", {iff1_o, iff2_o}, 2'b00);

    // R3 no sampling without insn_end, and none at EI/DI end
    do_ei();
    set_mode(2'd1);
    @(negedge clk); int_i = 1;
    @(negedge clk); int_i = 0;
    chk("R3 no end no take", take_int_o, 0);
    do_di();
    @(negedge clk); op_ei_i = 1; insn_end_i = 1; int_i = 1;
    @(negedge clk); op_ei_i = 0; insn_end_i = 0; int_i = 0;
    chk("R3 ei end no take", take_int_o, 0);
    chk("R3 ei applied", iff1_o, 1);
    @(negedge clk); op_di_i = 1; insn_end_i = 1; nmi_i = 1;
    @(negedge clk); op_di_i = 0; insn_end_i = 0; nmi_i = 0;
    chk("R3 di end no nmi", take_nmi_o, 0);

    // R9 mode select, code 3 ignored
    set_mode(2'd2);
    chk("R9 mode 2", mode_o, 2);
    set_mode(2'd3);
    chk("R9 code 3 ignored", mode_o, 2);
    set_mode(2'd0);
    chk("R9 mode 0", mode_o, 0);

    // R10 and R11: save across NMI then restore
    do_ei();
    @(negedge clk); nmi_i = 1; insn_end_i = 1;
    @(negedge clk); nmi_i = 0; insn_end_i = 0;
    chk("R10 after nmi", {iff1_o, iff2_o}, 2'b01);
    do_ldair();
    chk("R11 pv from iff2", pv_o, 1);
    do_retn();
    chk("R10 restored", iff1_o, 1);
    do_di();
    @(negedge clk);
    chk("R11 pv holds", pv_o, 1);
    do_ldair();
    chk("R11 pv zero", pv_o, 0);

    // R12 requests during acknowledge are not taken
    do_ei();
    set_mode(2'd1);
    @(negedge clk); int_i = 1; insn_end_i = 1;
    @(negedge clk); int_i = 0; nmi_i = 1;
    chk("R12 in wait", ack_wait_o, 1);
    @(negedge clk); nmi_i = 0; insn_end_i = 0;
    chk("R12 no nmi take", take_nmi_o, 0);
    @(negedge clk);
    chk("R12 int target", tgt_addr_o, 16'h0038);
    chk("R12 iff after", iff1_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule